// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble Hunt

This block turns a Manchester-coded serial line into a stream of data bits. Every clock cycle is one sub-sample, and sixteen sub-samples make one bit period. A free-running phase counter marks where each bit is expected. The line is read once in the first half of the bit and once in the second half. A bit whose two halves differ is a valid symbol. A bit whose two halves are equal breaks the code.

After reset the receiver can hunt for a preamble of a chosen shape and length before it delivers any data. The preamble is always judged under the default bit polarity. Once the preamble is complete the receiver emits a one-cycle found pulse and decodes every following bit period, applying the selected polarity. An optional drift mode pulls the phase counter back into line whenever a mid-bit transition arrives close to where it is expected. This lets the receiver follow a transmitter whose bit period is slightly off.

There are two states. HUNT is where preamble matching takes place. DATA is where bits are decoded. Reset enters HUNT when the preamble length is non-zero and DATA when it is zero. The only transition is HUNT to DATA, taken at the decision point of the bit that completes the preamble. DATA holds until the next reset.

Top module: `mrx_rx`

## Requirements
- R1: The phase counter starts at 0 on the first clock after reset and advances once per clock, with sixteen clocks per bit. The first half-bit is sampled at phase 4 and the second half-bit at phase 12. A bit is one when its first half is high and its second half is low, and zero for the opposite case. Each decoded bit raises `bit_valid` for exactly one cycle, in the cycle after phase 12, with `bit_data` holding the bit.
- R2: With `cfg_pol` = 1 every decoded data bit is inverted: a low-then-high bit gives one and a high-then-low bit gives zero.
- R3: In DATA, a bit with equal halves raises `code_err` for one cycle instead of `bit_valid`. `code_err` and `bit_valid` are never high together.
- R4: With `cfg_len` = 0 the receiver decodes from the first bit after reset and never raises `pre_found`.
- R5: `cfg_pat` selects the preamble shape: 0 is all ones, 1 is all zeros, 2 alternates starting with zero, and 3 alternates starting with one. Bits are judged by first-half level (high = one), whatever the value of `cfg_pol`.
- R6: After `cfg_len` consecutive matching preamble bits, `pre_found` pulses for one cycle, the state becomes DATA, and the next bit period is the first data bit. No data bit is produced before that point.
- R7: While hunting, a bit that breaks the shape or has equal halves sets the match count back to zero, and it does not raise `code_err`.
- R8: With `cfg_drift` = 0 the phase counter never skips or repeats a value, so a line whose bit period is 17 clocks is eventually mis-decoded.
- R9: With `cfg_drift` = 1, a line transition first seen at phase 6 to 10 loads phase 9 on the next clock. A line whose bit period is 15 or 17 clocks is then decoded without error.
- R10: While `rst` is high, and in the cycle after it falls, `bit_valid`, `pre_found` and `code_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-sample clock, 16 per bit |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Serial line, synchronous to clk |
| cfg_pol | input | 1 | Data bit polarity select |
| cfg_pat | input | 2 | Preamble shape code |
| cfg_len | input | 4 | Preamble length in bits, 0 disables the hunt |
| cfg_drift | input | 1 | Enables re-alignment on mid-bit transitions |
| bit_data | output | 1 | Last decoded data bit |
| bit_valid | output | 1 | One-cycle strobe for bit_data |
| pre_found | output | 1 | One-cycle pulse when the preamble completes |
| code_err | output | 1 | One-cycle pulse for a data bit with equal halves |

## Verification
The bench runs every shape code under both polarities at lengths 1, 2, 7 and 15, with two non-matching bits in front of each preamble. A matcher that honoured `cfg_pol` or that miscounted the length would then fire late, fire early, or drop the first data bits. A preamble broken one bit short of completion checks that the count really restarts. A receiver that kept its partial count would announce the preamble four bits too soon. Streams with 15- and 17-clock bits separate a working re-alignment from a fixed phase: a broken window lets errors accumulate, and a resync with the drift mode off would hide the 17-clock failure the bench expects. Equal-half bits in DATA must produce error pulses without stray data bits.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    // Receiver states
    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_DATA = 1'b1
    } mrx_state_e;

    // Preamble shape codes
    localparam logic [1:0] PAT_ONES  = 2'd0;
    localparam logic [1:0] PAT_ZEROS = 2'd1;
    localparam logic [1:0] PAT_ZO    = 2'd2;
    localparam logic [1:0] PAT_OZ    = 2'd3;

    // Expected default-polarity bit of a shape at a given match index parity
    function automatic logic shape_bit(input logic [1:0] pat, input logic odd);
        logic b;
        unique case (pat)
            PAT_ONES:  b = 1'b1;
            PAT_ZEROS: b = 1'b0;
            PAT_ZO:    b = odd;
            default:   b = ~odd;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mrx_phase.sv
module mrx_phase #(
    parameter int OSR = 16,
    parameter int WIN = 2,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_in,
    input  logic            drift_en,
    output logic [PH_W-1:0] phase
);
    localparam int MID = OSR / 2;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] WIN_LO  = PH_W'(MID - WIN);
    localparam logic [PH_W-1:0] WIN_HI  = PH_W'(MID + WIN);
    localparam logic [PH_W-1:0] PH_SYNC = PH_W'(MID + 1);

    logic line_q;
    logic resync;

    // Re-alignment exists only at 16x oversampling
    generate
        if (OSR == 16) begin : g_drift
            assign resync = drift_en && (line_in != line_q)
                            && (phase >= WIN_LO) && (phase <= WIN_HI);
        end else begin : g_fixed
            assign resync = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= '0;
            line_q <= line_in;
        end else begin
            line_q <= line_in;
            if (resync)
                phase <= PH_SYNC;
            else if (phase == PH_LAST)
                phase <= '0;
            else
                phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/mrx_slicer.sv
module mrx_slicer #(
    parameter int OSR = 16,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            line_in,
    input  logic [PH_W-1:0] phase,
    output logic            decide,
    output logic            raw_bit,
    output logic            sym_ok
);
    localparam logic [PH_W-1:0] PH_EARLY = PH_W'(OSR / 4);
    localparam logic [PH_W-1:0] PH_LATE  = PH_W'((3 * OSR) / 4);

    logic half_a;

    always_ff @(posedge clk) begin
        if (rst)
            half_a <= 1'b0;
        else if (phase == PH_EARLY)
            half_a <= line_in;
    end

    // Default polarity: the first half level is the bit value
    assign decide  = (phase == PH_LATE);
    assign raw_bit = half_a;
    assign sym_ok  = (half_a != line_in);

endmodule

// File: rtl/mrx_hunt.sv
module mrx_hunt #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             raw_bit,
    input  logic             sym_ok,
    input  logic [1:0]       cfg_pat,
    input  logic [LEN_W-1:0] cfg_len,
    output logic             done
);
    import mrx_pkg::*;

    logic [LEN_W-1:0] match_q;
    logic             hit;

    assign hit  = sym_ok && (raw_bit == shape_bit(cfg_pat, match_q[0]));
    assign done = step && hit && ((match_q + LEN_W'(1)) == cfg_len);

    always_ff @(posedge clk) begin
        if (rst)
            match_q <= '0;
        else if (step) begin
            if (hit && !done)
                match_q <= match_q + LEN_W'(1);
            else
                match_q <= '0;
        end
    end

endmodule

// File: rtl/mrx_rx.sv
module mrx_rx #(
    parameter int OSR   = 16,
    parameter int WIN   = 2,
    parameter int LEN_W = 4,
    localparam int PH_W = $clog2(OSR)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    input  logic             cfg_pol,
    input  logic [1:0]       cfg_pat,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_drift,
    output logic             bit_data,
    output logic             bit_valid,
    output logic             pre_found,
    output logic             code_err
);
    import mrx_pkg::*;

    mrx_state_e      state, state_n;
    logic [PH_W-1:0] phase;
    logic            decide, raw_bit, sym_ok, hunt_done;

    mrx_phase #(.OSR(OSR), .WIN(WIN)) u_phase (
        .clk(clk), .rst(rst), .line_in(line_in),
        .drift_en(cfg_drift), .phase(phase)
    );

    mrx_slicer #(.OSR(OSR)) u_slicer (
        .clk(clk), .rst(rst), .line_in(line_in), .phase(phase),
        .decide(decide), .raw_bit(raw_bit), .sym_ok(sym_ok)
    );

    mrx_hunt #(.LEN_W(LEN_W)) u_hunt (
        .clk(clk), .rst(rst), .step(decide && (state == ST_HUNT)),
        .raw_bit(raw_bit), .sym_ok(sym_ok),
        .cfg_pat(cfg_pat), .cfg_len(cfg_len), .done(hunt_done)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT: if (hunt_done) state_n = ST_DATA;
            ST_DATA: state_n = ST_DATA;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= (cfg_len == '0) ? ST_DATA : ST_HUNT;
        else
            state <= state_n;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_data  <= 1'b0;
            bit_valid <= 1'b0;
            pre_found <= 1'b0;
            code_err  <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            code_err  <= 1'b0;
            pre_found <= hunt_done;
            if (decide && (state == ST_DATA)) begin
                if (sym_ok) begin
                    bit_valid <= 1'b1;
                    bit_data  <= raw_bit ^ cfg_pol;
                end else begin
                    code_err <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mrx_rx_chk.sv
module mrx_rx_chk #(
    parameter int OSR = 16,
    localparam int PH_W = $clog2(OSR)
) (
    input logic               clk,
    input logic               rst,
    input logic               cfg_drift,
    input logic [3:0]         cfg_len,
    input logic [PH_W-1:0]    phase,
    input mrx_pkg::mrx_state_e state,
    input logic               bit_valid,
    input logic               code_err,
    input logic               pre_found
);
    import mrx_pkg::*;

    function automatic logic [PH_W-1:0] ph_next(input logic [PH_W-1:0] p);
        return (p == PH_W'(OSR - 1)) ? '0 : p + 1'b1;
    endfunction

    // R3
    excl_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && code_err));

    // R6
    found_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pre_found |=> !pre_found);

    // R6
    found_state_chk: assert property (@(posedge clk) disable iff (rst)
        pre_found |-> (state == ST_DATA));

    // R4
    no_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_len == 4'd0) |-> !pre_found);

    // R1
    valid_gap_chk: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);

    // R6
    valid_state_chk: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> ($past(state) == ST_DATA));

    // R8
    fixed_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_drift && !$past(rst)) |-> (phase == ph_next($past(phase))));

    // R9
    resync_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (phase != ph_next($past(phase))))
            |-> (cfg_drift && (phase == PH_W'(OSR / 2 + 1))));

endmodule

bind mrx_rx mrx_rx_chk #(.OSR(OSR)) u_chk (
    .clk(clk), .rst(rst), .cfg_drift(cfg_drift), .cfg_len(cfg_len),
    .phase(phase), .state(state), .bit_valid(bit_valid),
    .code_err(code_err), .pre_found(pre_found)
);

// File: tb/mrx_rx_test.sv
module mrx_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_in = 1'b0;
    logic       cfg_pol = 1'b0;
    logic [1:0] cfg_pat = 2'd0;
    logic [3:0] cfg_len = 4'd0;
    logic       cfg_drift = 1'b0;
    logic       bit_data, bit_valid, pre_found, code_err;

    int n_chk = 0;
    int n_bad = 0;
    logic rx_q [0:63];
    int rx_n = 0, err_n = 0, found_n = 0, found_at = -1;
    logic sent_q [0:63];
    int sent_n = 0;

    always #10 clk = ~clk;

    mrx_rx uut (
        .clk(clk), .rst(rst), .line_in(line_in), .cfg_pol(cfg_pol),
        .cfg_pat(cfg_pat), .cfg_len(cfg_len), .cfg_drift(cfg_drift),
        .bit_data(bit_data), .bit_valid(bit_valid),
        .pre_found(pre_found), .code_err(code_err)
    );

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid && rx_n < 64) begin
                rx_q[rx_n] = bit_data;
                rx_n = rx_n + 1;
            end
            if (code_err) err_n = err_n + 1;
            if (pre_found) begin
                found_n = found_n + 1;
                found_at = rx_n;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_shape(input int pat, input int idx);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return idx[0];
            default: return ~idx[0];
        endcase
    endfunction

    task automatic start(input logic pol, input int pat, input int len, input logic drift);
        @(negedge clk);
        rst = 1'b1; line_in = 1'b0;
        cfg_pol = pol; cfg_pat = 2'(pat); cfg_len = 4'(len); cfg_drift = drift;
        repeat (3) @(negedge clk);
        rx_n = 0; err_n = 0; found_n = 0; found_at = -1; sent_n = 0;
        rst = 1'b0;
    endtask

    // Drive one bit period as two halves; the second half is per-8 clocks
    task automatic send_halves(input logic a, input logic b, input int per);
        line_in = a;
        repeat (8) @(negedge clk);
        line_in = b;
        repeat (per - 8) @(negedge clk);
    endtask

    task automatic send_raw(input logic b, input int per);
        send_halves(b, ~b, per);
    endtask

    task automatic send_data(input logic d, input int per);
        send_raw(d ^ cfg_pol, per);
        sent_q[sent_n] = d;
        sent_n = sent_n + 1;
    endtask

    task automatic compare_rx(input string req);
        int miss = 0;
        check(req, rx_n, sent_n);
        for (int i = 0; i < sent_n && i < rx_n; i++)
            if (rx_q[i] !== sent_q[i]) miss++;
        check(req, miss, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int lens [4] = '{1, 2, 7, 15};
        logic [23:0] pat24 = 24'hA5C396;

        // R10 outputs held low in reset and just after it
        repeat (2) @(negedge clk);
        check("R10 reset valid", int'(bit_valid), 0);
        check("R10 reset found", int'(pre_found), 0);
        check("R10 reset err", int'(code_err), 0);
        start(1'b0, 0, 0, 1'b0);
        @(negedge clk);
        check("R10 post-reset strobes", int'(bit_valid | pre_found | code_err), 0);

        // R4 R1 no preamble, default polarity
        start(1'b0, 0, 0, 1'b0);
        for (int i = 0; i < 12; i++) send_data(pat24[i], 16);
        compare_rx("R1 R4 direct decode");
        check("R4 no found pulse", found_n, 0);

        // R2 inverted polarity
        start(1'b1, 0, 0, 1'b0);
        for (int i = 0; i < 12; i++) send_data(pat24[i + 5], 16);
        compare_rx("R2 inverted decode");

        // R5 R6 sweep of shape, length and polarity
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 4; k++) begin
                    logic [7:0] d = 8'(37 * (p * 16 + s * 4 + k) + 11);
                    start(1'(p), s, lens[k], 1'b0);
                    send_raw(~exp_shape(s, 0), 16);
                    send_raw(~exp_shape(s, 0), 16);
                    for (int i = 0; i < lens[k]; i++) send_raw(exp_shape(s, i), 16);
                    check("R6 found before data", found_n, 1);
                    for (int i = 0; i < 8; i++) send_data(d[i], 16);
                    compare_rx("R5 R6 data after preamble");
                    check("R6 found position", found_at, 0);
                    check("R5 single found", found_n, 1);
                end

        // R7 shape break restarts count
        start(1'b0, 2, 5, 1'b0);
        for (int i = 0; i < 4; i++) send_raw(exp_shape(2, i), 16);
        send_raw(~exp_shape(2, 4), 16);
        for (int i = 0; i < 4; i++) send_raw(exp_shape(2, i), 16);
        check("R7 no early found", found_n, 0);
        send_raw(exp_shape(2, 4), 16);
        check("R7 found after restart", found_n, 1);
        for (int i = 0; i < 4; i++) send_data(pat24[i + 9], 16);
        compare_rx("R7 data after restart");

        // R7 equal-half bit while hunting restarts count, no error pulse
        start(1'b0, 0, 5, 1'b0);
        for (int i = 0; i < 4; i++) send_raw(1'b1, 16);
        send_halves(1'b1, 1'b1, 16);
        for (int i = 0; i < 4; i++) send_raw(1'b1, 16);
        check("R7 no found after violation", found_n, 0);
        check("R7 no error while hunting", err_n, 0);
        send_raw(1'b1, 16);
        check("R7 found after violation", found_n, 1);

        // R3 code errors in data
        start(1'b0, 0, 0, 1'b0);
        send_data(1'b1, 16);
        send_halves(1'b1, 1'b1, 16);
        send_data(1'b0, 16);
        send_halves(1'b0, 1'b0, 16);
        send_data(1'b1, 16);
        compare_rx("R3 good bits kept");
        check("R3 error pulses", err_n, 2);

        // R9 drift recovery with long and short bits
        start(1'b0, 0, 0, 1'b1);
        for (int i = 0; i < 24; i++) send_data(pat24[i], 17);
        compare_rx("R9 long bits");
        check("R9 long bits no error", err_n, 0);
        start(1'b1, 0, 0, 1'b1);
        for (int i = 0; i < 24; i++) send_data(pat24[23 - i], 15);
        compare_rx("R9 short bits");
        check("R9 short bits no error", err_n, 0);

        // R8 fixed phase loses long bits
        start(1'b0, 0, 0, 1'b0);
        for (int i = 0; i < 24; i++) send_data(pat24[i], 17);
        begin
            int bad = err_n + ((rx_n != sent_n) ? 1 : 0);
            for (int i = 0; i < sent_n && i < rx_n; i++)
                if (rx_q[i] !== sent_q[i]) bad++;
            check("R8 fixed phase misdecodes", int'(bad > 0), 1);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule